// File: doc/BRIEF.md
# Control Register Table Reload Engine

This block refills seven live display-controller control registers from a small table held in memory. Software first programs a table base address, which always lies on a 1 KB boundary, and then sets a start bit. The engine waits until the vertical non-display period. It then reads seven consecutive 32-bit words from the table through a request/acknowledge read port. Each word is copied unchanged into the control register it belongs to.

Several tables can sit in memory at once. The base address alone selects which one is used. The start bit reads as 1 while the reload is in progress and clears itself when the last word has landed. A reload that has started always runs to its end, even if blanking finishes partway through.

Top module: `reload_table_engine`

## Requirements
- R1: After a synchronous reset, all seven register outputs are zero, the base and start bits read as zero, and no memory request is raised.
- R2: Host address 0 holds the table base. Only data bits [31:10] are stored, and a read at address 0 returns bits [9:0] as zero.
- R3: Writing a 1 to bit 0 at host address 1 starts a reload. That bit reads as 1 until the last table word has been written, and then reads as 0 again without any further host action.
- R4: Writing 0 to the start bit has no effect. A write of 1 to the start bit during a reload is ignored. A write to the base during a reload is ignored, so the base reads back unchanged afterwards.
- R5: While the vertical blank input is low, no memory request is issued. The first read of a reload waits for vblank to be high.
- R6: A reload issues exactly seven reads, at base + 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18, in that order. Each request and its address are held until the request is acknowledged.
- R7: The word at offset 4*i is copied bit for bit into output i. Output i runs, in order: display mode, main start address, main address offset, sub start address, sub address offset, sub start position, sub end position. An output changes only in the cycle after an acknowledge for its word.
- R8: Once the first read has been issued, the reload runs to completion even if vblank falls before the end.
- R9: Reloads from different base addresses load the contents of their own tables, so the selected table depends only on the programmed base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 1 | Host write address (0 = base, 1 = control) |
| host_wr_data | input | 32 | Host write data |
| host_rd_addr | input | 1 | Host read address |
| host_rd_data | output | 32 | Host read data, combinational |
| vblank | input | 1 | High during the vertical non-display period |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 32 | Memory byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; mem_rdata is valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| disp_mode_o | output | 32 | Display mode register |
| main_base_o | output | 32 | Main window start address register |
| main_pitch_o | output | 32 | Main address offset register |
| sub_base_o | output | 32 | Sub-window start address register |
| sub_pitch_o | output | 32 | Sub-window address offset register |
| sub_start_pos_o | output | 32 | Sub-window start position register |
| sub_end_pos_o | output | 32 | Sub-window end position register |

## Verification
A word index that is stuck or skipped shows up at once on mem_addr. It also lands a table word in the wrong output, and the bench's per-output comparison catches that after the reload ends. A sequencer that leaves its fetch state too early or too late changes the number of acknowledged reads, and the start bit clears at the wrong moment; both are visible at the ports within a few cycles of the seventh acknowledge. A wait state that ignores vblank raises mem_req during active display, and the bench watches for that over several idle cycles before blanking begins.

// File: rtl/reload_pkg.sv
package reload_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_REGS  = 7;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int ALIGN_LSB = 10;
    localparam int BASE_W    = WORD_W - ALIGN_LSB;

    localparam logic HOST_SEL_BASE = 1'b0;
    localparam logic HOST_SEL_CTRL = 1'b1;

    typedef enum logic [IDX_W-1:0] {
        IDX_DISP_MODE  = 3'd0,
        IDX_MAIN_BASE  = 3'd1,
        IDX_MAIN_PITCH = 3'd2,
        IDX_SUB_BASE   = 3'd3,
        IDX_SUB_PITCH  = 3'd4,
        IDX_SUB_START  = 3'd5,
        IDX_SUB_END    = 3'd6
    } reg_idx_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_BLANK,
        ST_FETCH
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } bank_wr_t;

    function automatic logic [WORD_W-1:0] word_addr(
        input logic [BASE_W-1:0] base,
        input logic [IDX_W-1:0]  idx
    );
        return {base, {ALIGN_LSB{1'b0}}} | (WORD_W'(idx) << 2);
    endfunction
endpackage

// File: rtl/reload_host_regs.sv
module reload_host_regs
    import reload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_addr,
    input  logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic [BASE_W-1:0] base,
    output logic              busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            busy <= 1'b0;
        end else begin
            if (wr_en && wr_addr == HOST_SEL_BASE && !busy)
                base <= wr_data[WORD_W-1:ALIGN_LSB];
            if (done)
                busy <= 1'b0;
            else if (wr_en && wr_addr == HOST_SEL_CTRL && wr_data[0])
                busy <= 1'b1;
        end
    end

    always_comb begin
        if (rd_addr == HOST_SEL_BASE)
            rd_data = {base, {ALIGN_LSB{1'b0}}};
        else
            rd_data = {{(WORD_W-1){1'b0}}, busy};
    end

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R3
    AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(base)); // R4
endmodule

// File: rtl/reload_sequencer.sv
module reload_sequencer
    import reload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              vblank,
    input  logic [BASE_W-1:0] base,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output bank_wr_t          bank_wr,
    output logic              done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (busy) state <= ST_WAIT_BLANK;
                end
                ST_WAIT_BLANK: begin
                    if (vblank) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (idx == LAST_IDX) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req       = (state == ST_FETCH);
        mem_addr      = word_addr(base, idx);
        bank_wr.valid = mem_req && mem_ack;
        bank_wr.idx   = idx;
        bank_wr.data  = mem_rdata;
        done          = bank_wr.valid && (idx == LAST_IDX);
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R6
    AST_NO_FETCH_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_BLANK && !vblank) |=> !mem_req); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R3
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R6
endmodule

// File: rtl/reload_bank.sv
module reload_bank
    import reload_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  bank_wr_t                       wr,
    output logic [NUM_REGS-1:0][WORD_W-1:0] regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr.valid && wr.idx == IDX_W'(g))
                regs[g] <= wr.data;
        end
    end
endmodule

// File: rtl/reload_table_engine.sv
module reload_table_engine
    import reload_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr_en,
    input  logic        host_wr_addr,
    input  logic [31:0] host_wr_data,
    input  logic        host_rd_addr,
    output logic [31:0] host_rd_data,
    input  logic        vblank,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic [31:0] disp_mode_o,
    output logic [31:0] main_base_o,
    output logic [31:0] main_pitch_o,
    output logic [31:0] sub_base_o,
    output logic [31:0] sub_pitch_o,
    output logic [31:0] sub_start_pos_o,
    output logic [31:0] sub_end_pos_o
);
    logic [BASE_W-1:0]              base;
    logic                           busy;
    logic                           done;
    bank_wr_t                       bank_wr;
    logic [NUM_REGS-1:0][WORD_W-1:0] regs;

    reload_host_regs host_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (host_wr_en),
        .wr_addr (host_wr_addr),
        .wr_data (host_wr_data),
        .rd_addr (host_rd_addr),
        .done    (done),
        .rd_data (host_rd_data),
        .base    (base),
        .busy    (busy)
    );

    reload_sequencer seq_i (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .vblank    (vblank),
        .base      (base),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .bank_wr   (bank_wr),
        .done      (done)
    );

    reload_bank bank_i (
        .clk  (clk),
        .rst  (rst),
        .wr   (bank_wr),
        .regs (regs)
    );

    assign disp_mode_o     = regs[IDX_DISP_MODE];
    assign main_base_o     = regs[IDX_MAIN_BASE];
    assign main_pitch_o    = regs[IDX_MAIN_PITCH];
    assign sub_base_o      = regs[IDX_SUB_BASE];
    assign sub_pitch_o     = regs[IDX_SUB_PITCH];
    assign sub_start_pos_o = regs[IDX_SUB_START];
    assign sub_end_pos_o   = regs[IDX_SUB_END];

    AST_WRITE_ON_ACK_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && mem_ack) |=> $stable(regs)); // R7
    AST_TABLE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[9:0] < 10'(4 * NUM_REGS))); // R6
endmodule

// File: tb/reload_table_engine_tb.sv
module reload_table_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic        host_wr_addr = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        host_rd_addr = 1'b0;
    logic [31:0] host_rd_data;
    logic        vblank = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] outs [7];

    int n_tests = 0;
    int n_fail  = 0;
    int lat     = 0;
    int lat_cnt = 0;
    int nreads  = 0;
    logic [31:0] rlog [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_table_engine dut_i (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .host_rd_addr(host_rd_addr),
        .host_rd_data(host_rd_data), .vblank(vblank),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .disp_mode_o(outs[0]), .main_base_o(outs[1]), .main_pitch_o(outs[2]),
        .sub_base_o(outs[3]), .sub_pitch_o(outs[4]),
        .sub_start_pos_o(outs[5]), .sub_end_pos_o(outs[6])
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A_0000;
    endfunction

    // memory model: acknowledges after lat idle cycles
    always @(negedge clk) begin
        if (mem_req) begin
            if (lat_cnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_word(mem_addr);
                if (nreads < 16) rlog[nreads] <= mem_addr;
                nreads    <= nreads + 1;
                lat_cnt   <= 0;
            end else begin
                mem_ack <= 1'b0;
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic a, output logic [31:0] d);
        host_rd_addr = a;
        #1;
        d = host_rd_data;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_reload(input logic [31:0] base_in, input int l);
        logic [31:0] rd;
        logic [31:0] base_al;
        int to;
        base_al = base_in & 32'hFFFF_FC00;
        lat = l;
        vblank = 1'b0;
        host_write(1'b0, base_in | 32'h0000_03FF);
        host_read(1'b0, rd);
        check("R2 base readback", rd, base_al);
        host_write(1'b1, 32'h0);
        wait_cycles(3);
        host_read(1'b1, rd);
        check("R4 write 0 no start", rd, 32'h0);
        check("R4 write 0 no request", {31'h0, mem_req}, 32'h0);
        @(negedge clk);
        nreads = 0;
        host_write(1'b1, 32'h1);
        wait_cycles(8);
        host_read(1'b1, rd);
        check("R3 start bit reads 1", rd, 32'h1);
        check("R5 no read during active display", nreads, 0);
        check("R5 no request during active display", {31'h0, mem_req}, 32'h0);
        vblank = 1'b1;
        to = 0;
        while (nreads < 2 && to < 200) begin @(negedge clk); to++; end
        vblank = 1'b0;                          // R8: blank ends mid-reload
        host_write(1'b0, 32'hAAAA_A800);        // R4: ignored while busy
        host_write(1'b1, 32'h1);                // R4: ignored while busy
        to = 0;
        host_read(1'b1, rd);
        while (rd[0] && to < 500) begin @(negedge clk); host_read(1'b1, rd); to++; end
        check("R3 start bit self-clears", rd, 32'h0);
        check("R8 all seven words read", nreads, 7);
        for (int i = 0; i < 7; i++) begin
            check("R6 read address order", rlog[i], base_al + 32'(4 * i));
            check("R7/R9 register from own table", outs[i], mem_word(base_al + 32'(4 * i)));
        end
        host_read(1'b0, rd);
        check("R4 base write ignored while busy", rd, base_al);
        wait_cycles(12);
        check("R4 extra start ignored, no further reads", nreads, 7);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] bases [4];
        bases[0] = 32'h0000_0000;
        bases[1] = 32'h0000_0400;
        bases[2] = 32'hFFFF_FC00;
        bases[3] = 32'h1234_5FFF;
        wait_cycles(4);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 7; i++) check("R1 register reset", outs[i], 32'h0);
        host_read(1'b0, rd);
        check("R1 base reset", rd, 32'h0);
        host_read(1'b1, rd);
        check("R1 start reset", rd, 32'h0);
        check("R1 no request", {31'h0, mem_req}, 32'h0);
        for (int b = 0; b < 4; b++)
            for (int l = 0; l < 3; l++)
                run_reload(bases[b], l);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule